// File: doc/BRIEF.md
# Microcoded instruction control sequencer

This block is the control unit of a small single-bus accumulator processor. It keeps the opcode being executed, a three-bit microstep counter and a staged opcode that the previous microprogram fetched ahead of time. On every clock it presents one registered control word. Each bit of that word is a strobe for the shared bus, the A, B and I registers, the ALU temporary register and its result, the program counter, or memory. The datapath, the ALU and the memory sit outside the block. The datapath returns three things: the bus value, the overflow flag, and a flag that says the program counter was overwritten.

Each opcode has its own fixed microprogram. Every microprogram except the conditional jump ends with a common fetch tail. The tail advances the program counter, drives it onto the bus, latches the memory word into the staging register, and then spends one step resetting the microstep counter. The conditional jump has two microprograms, and the overflow flag decides between them when the jump is entered. Opcodes with no defined microprogram run a harmless fetch-only sequence, so the sequencer can never stall.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is held, op_o is 8, step_o is 0 and ctrl_o has only bits 0 and 17 set.
- R2: The ctrl_o bits are:
  - 0: PC increment
  - 1: PC drives the bus
  - 2: memory drives the bus
  - 3: A drives the bus
  - 4: B drives the bus
  - 5: I drives the bus
  - 6: ALU temporary drives the bus
  - 7: ALU result drives the bus
  - 8: PC load
  - 9: staged opcode load
  - 10: memory write
  - 11: A load
  - 12: B load
  - 13: I load
  - 14: ALU temporary load
  - 15: add
  - 16: increment
  - 17: overflow clear
  - 18: overflow set
  - 19: step reset

  No cycle has more than one of bits 1 to 7 set.
- R3: After a cycle without bit 19, step_o is one higher and op_o is unchanged. After a cycle with bit 19 and jump_in low, step_o is 0 and op_o takes the value of bus_in sampled in the most recent cycle that had bit 9.
- R4: After a cycle with bit 19 and jump_in high, op_o takes the value of bus_in sampled in that same cycle.
- R5: Every microprogram except opcode 1 ends with four steps: {0}, {1}, {2,9}, {19}.
- R6: ADD (code 0) begins with {3,14,17}, {4,15}, {7,11}. INC (code 7) begins with {3,14,17}, {16}, {7,11}.
- R7: LIT (code 2) begins with {0}, {1}, {2,12}. LOAD (code 3) begins with {5}, {2,12}. STOR (code 4) begins with {5}, {4,10}.
- R8: SWAP (code 5) begins with {3,14}, {4,11}, {6,12}. SWPI (code 6) begins with {4,14}, {5,12}, {6,13}.
- R9: NOP (code 8) is the fetch tail, with bit 17 added to its first step: {0,17}, {1}, {2,9}, {19}.
- R10: The jump (code 1) samples ovf_in in the step-reset cycle that enters it. If ovf_in was high there, the jump runs {4,8}, {17}, {19}. Changes of ovf_in later in the program do not alter the sequence.
- R11: If ovf_in was low when the jump (code 1) was entered, the jump runs {0}, {1}, {2,9,18}, {19}.
- R12: Any opcode value above 8, including the reserved values 9 to 12, runs {0}, {1}, {2,9}, {19}, with bit 17 never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | DW | Current value of the shared bus |
| ovf_in | input | 1 | Overflow flag from the datapath |
| jump_in | input | 1 | High when the program counter has been overwritten |
| ctrl_o | output | 20 | Registered control word for the current step |
| op_o | output | DW | Opcode being executed |
| step_o | output | 3 | Microstep within the current microprogram |

## Verification
The bench builds the block with its default 8-bit bus word. With that width, bus values from 13 to 255 reach the undefined-opcode path alongside the reserved codes 9 to 12. Random bus, overflow and jump inputs are each held for a single cycle. This lets a jump start with either overflow state and then see the flag change while it runs, and it lets refetches after a jump land on arbitrary words.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  input  logic          ovf_in,
  input  logic          jump_in,
  output logic [19:0]   ctrl_o,
  output logic [DW-1:0] op_o,
  output logic [2:0]    step_o
);

  localparam logic [19:0] M_PC_INC   = 20'h1 << 0;
  localparam logic [19:0] M_PC_DRV   = 20'h1 << 1;
  localparam logic [19:0] M_MEM_DRV  = 20'h1 << 2;
  localparam logic [19:0] M_A_DRV    = 20'h1 << 3;
  localparam logic [19:0] M_B_DRV    = 20'h1 << 4;
  localparam logic [19:0] M_I_DRV    = 20'h1 << 5;
  localparam logic [19:0] M_T_DRV    = 20'h1 << 6;
  localparam logic [19:0] M_ALU_DRV  = 20'h1 << 7;
  localparam logic [19:0] M_PC_LD    = 20'h1 << 8;
  localparam logic [19:0] M_IR_LD    = 20'h1 << 9;
  localparam logic [19:0] M_MEM_WR   = 20'h1 << 10;
  localparam logic [19:0] M_A_LD     = 20'h1 << 11;
  localparam logic [19:0] M_B_LD     = 20'h1 << 12;
  localparam logic [19:0] M_I_LD     = 20'h1 << 13;
  localparam logic [19:0] M_T_LD     = 20'h1 << 14;
  localparam logic [19:0] M_ALU_ADD  = 20'h1 << 15;
  localparam logic [19:0] M_ALU_INC  = 20'h1 << 16;
  localparam logic [19:0] M_OV_CLR   = 20'h1 << 17;
  localparam logic [19:0] M_OV_SET   = 20'h1 << 18;
  localparam logic [19:0] M_STEP_RST = 20'h1 << 19;
  localparam int          RST_BIT    = 19;
  localparam int          IRLD_BIT   = 9;

  localparam logic [DW-1:0] OP_ADD  = DW'(0);
  localparam logic [DW-1:0] OP_JOV  = DW'(1);
  localparam logic [DW-1:0] OP_LIT  = DW'(2);
  localparam logic [DW-1:0] OP_LOAD = DW'(3);
  localparam logic [DW-1:0] OP_STOR = DW'(4);
  localparam logic [DW-1:0] OP_SWAP = DW'(5);
  localparam logic [DW-1:0] OP_SWPI = DW'(6);
  localparam logic [DW-1:0] OP_INC  = DW'(7);
  localparam logic [DW-1:0] OP_NOP  = DW'(8);

  localparam logic [19:0] RST_WORD = M_PC_INC | M_OV_CLR;

  logic [DW-1:0] op_q, staged_q, op_n;
  logic [2:0]    step_q, step_n;
  logic          path_q, path_n;
  logic [19:0]   word_n;

  function automatic logic [19:0] tail_word(input logic [2:0] k);
    case (k)
      3'd0:    tail_word = M_PC_INC;
      3'd1:    tail_word = M_PC_DRV;
      3'd2:    tail_word = M_MEM_DRV | M_IR_LD;
      default: tail_word = M_STEP_RST;
    endcase
  endfunction

  function automatic logic [19:0] jump_word(input logic [2:0] st, input logic taken);
    if (taken) begin
      case (st)
        3'd0:    jump_word = M_B_DRV | M_PC_LD;
        3'd1:    jump_word = M_OV_CLR;
        default: jump_word = M_STEP_RST;
      endcase
    end else begin
      case (st)
        3'd0:    jump_word = M_PC_INC;
        3'd1:    jump_word = M_PC_DRV;
        3'd2:    jump_word = M_MEM_DRV | M_IR_LD | M_OV_SET;
        default: jump_word = M_STEP_RST;
      endcase
    end
  endfunction

  function automatic logic [19:0] micro_word(input logic [DW-1:0] op,
                                             input logic [2:0] st,
                                             input logic taken);
    logic [19:0] b0, b1, b2, w;
    logic [2:0]  len;
    b0 = '0;
    b1 = '0;
    b2 = '0;
    len = 3'd0;
    case (op)
      OP_ADD, OP_INC: begin
        len = 3'd3;
        b0 = M_A_DRV | M_T_LD | M_OV_CLR;
        b1 = (op == OP_ADD) ? (M_B_DRV | M_ALU_ADD) : M_ALU_INC;
        b2 = M_ALU_DRV | M_A_LD;
      end
      OP_LIT: begin
        len = 3'd3;
        b0 = M_PC_INC;
        b1 = M_PC_DRV;
        b2 = M_MEM_DRV | M_B_LD;
      end
      OP_LOAD: begin
        len = 3'd2;
        b0 = M_I_DRV;
        b1 = M_MEM_DRV | M_B_LD;
      end
      OP_STOR: begin
        len = 3'd2;
        b0 = M_I_DRV;
        b1 = M_B_DRV | M_MEM_WR;
      end
      OP_SWAP: begin
        len = 3'd3;
        b0 = M_A_DRV | M_T_LD;
        b1 = M_B_DRV | M_A_LD;
        b2 = M_T_DRV | M_B_LD;
      end
      OP_SWPI: begin
        len = 3'd3;
        b0 = M_B_DRV | M_T_LD;
        b1 = M_I_DRV | M_B_LD;
        b2 = M_T_DRV | M_I_LD;
      end
      default: len = 3'd0;
    endcase
    if (op == OP_JOV)
      w = jump_word(st, taken);
    else if (st < len)
      w = (st == 3'd0) ? b0 : (st == 3'd1) ? b1 : b2;
    else
      w = tail_word(st - len) | ((op == OP_NOP && st == 3'd0) ? M_OV_CLR : 20'h0);
    return w;
  endfunction

  assign op_n   = ctrl_o[RST_BIT] ? (jump_in ? bus_in : staged_q) : op_q;
  assign step_n = ctrl_o[RST_BIT] ? 3'd0 : step_q + 3'd1;
  assign path_n = ctrl_o[RST_BIT] ? ovf_in : path_q;
  assign word_n = micro_word(op_n, step_n, path_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_NOP;
      staged_q <= OP_NOP;
      step_q   <= 3'd0;
      path_q   <= 1'b0;
      ctrl_o   <= RST_WORD;
    end else begin
      if (ctrl_o[IRLD_BIT]) staged_q <= bus_in;
      op_q   <= op_n;
      step_q <= step_n;
      path_q <= path_n;
      ctrl_o <= word_n;
    end
  end

  assign op_o   = op_q;
  assign step_o = step_q;

endmodule

module useq_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] bus_in,
  input logic          ovf_in,
  input logic          jump_in,
  input logic [19:0]   ctrl_o,
  input logic [DW-1:0] op_o,
  input logic [2:0]    step_o
);

  // R2
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctrl_o[7:1]) <= 1);

  // R3
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[19] |=> step_o == 3'd0);

  // R3
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[19] |=> step_o == $past(step_o) + 3'd1);

  // R3
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[19] |=> $stable(op_o));

  // R4
  jump_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[19] && jump_in) |=> op_o == $past(bus_in));

  // R10
  jump_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o == DW'(1) && step_o == 3'd0 && ctrl_o[8]) |=> ctrl_o[17]);

  // R12
  undef_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o > DW'(8)) |-> !ctrl_o[17]);

  wire unused_ok = ovf_in;

endmodule

bind useq_ctrl useq_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ovf_in(ovf_in),
  .jump_in(jump_in), .ctrl_o(ctrl_o), .op_o(op_o), .step_o(step_o)
);

// File: tb/useq_ctrl_tb.sv
`timescale 1ns/1ps
module useq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_in;
  logic       ovf_in, jump_in;
  logic [19:0] ctrl_o;
  logic [7:0] op_o;
  logic [2:0] step_o;

  always #10 clk = ~clk;

  useq_ctrl #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ovf_in(ovf_in),
    .jump_in(jump_in), .ctrl_o(ctrl_o), .op_o(op_o), .step_o(step_o)
  );

  int checks = 0;
  int errors = 0;
  int m_op, m_step, m_staged;
  bit m_path, m_lastjump;

  function automatic logic [19:0] m(int a, int b = -1, int c = -1);
    logic [19:0] r = '0;
    r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    return r;
  endfunction

  function automatic logic [19:0] fetch_end(int k);
    if (k == 0) return m(0);
    if (k == 1) return m(1);
    if (k == 2) return m(2, 9);
    return m(19);
  endfunction

  function automatic logic [19:0] exp_word(int op, int st, bit pth);
    case (op)
      0: if (st == 0) return m(3, 14, 17); else if (st == 1) return m(4, 15);
         else if (st == 2) return m(7, 11); else return fetch_end(st - 3);
      7: if (st == 0) return m(3, 14, 17); else if (st == 1) return m(16);
         else if (st == 2) return m(7, 11); else return fetch_end(st - 3);
      1: if (pth) return (st == 0) ? m(4, 8) : (st == 1) ? m(17) : m(19);
         else return (st == 0) ? m(0) : (st == 1) ? m(1) : (st == 2) ? m(2, 9, 18) : m(19);
      2: if (st == 0) return m(0); else if (st == 1) return m(1);
         else if (st == 2) return m(2, 12); else return fetch_end(st - 3);
      3: if (st == 0) return m(5); else if (st == 1) return m(2, 12); else return fetch_end(st - 2);
      4: if (st == 0) return m(5); else if (st == 1) return m(4, 10); else return fetch_end(st - 2);
      5: if (st == 0) return m(3, 14); else if (st == 1) return m(4, 11);
         else if (st == 2) return m(6, 12); else return fetch_end(st - 3);
      6: if (st == 0) return m(4, 14); else if (st == 1) return m(5, 12);
         else if (st == 2) return m(6, 13); else return fetch_end(st - 3);
      8: if (st == 0) return m(0, 17); else return fetch_end(st);
      default: return fetch_end(st);
    endcase
  endfunction

  function automatic string tag_of(int op, bit pth);
    case (op)
      0, 7: return "R6";
      1: return pth ? "R10" : "R11";
      2, 3, 4: return "R7";
      5, 6: return "R8";
      8: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(int b, bit ov, bit jp);
    logic [19:0] w;
    int old_staged;
    w = exp_word(m_op, m_step, m_path);
    check(tag_of(m_op, m_path), (m_step >= 3) ? "word (tail R5)" : "word", ctrl_o, w);
    check("R2", "drivers", ($countones(ctrl_o[7:1]) <= 1), 1);
    check(m_lastjump ? "R4" : "R3", "op", op_o, m_op);
    check("R3", "step", step_o, m_step);
    bus_in = 8'(b);
    ovf_in = ov;
    jump_in = jp;
    old_staged = m_staged;
    if (w[9]) m_staged = b;
    if (w[19]) begin
      m_lastjump = jp;
      m_op = jp ? b : old_staged;
      m_step = 0;
      m_path = ov;
    end else m_step++;
    @(negedge clk);
  endtask

  initial begin
    #(4_000_000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int codes[14] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 12, 200, 255};
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    bus_in = '0;
    ovf_in = 1'b0;
    jump_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset op", op_o, 8);
    check("R1", "reset step", step_o, 0);
    check("R1", "reset word", ctrl_o, m(0, 17));
    m_op = 8; m_step = 0; m_staged = 8; m_path = 0; m_lastjump = 0;
    rst_n = 1'b1;
    @(negedge clk);
    m_step = 1;
    for (int v = 0; v < 2; v++)
      for (int k = 0; k < 14; k++)
        for (int n = 0; n < 16; n++) cyc(codes[k], v[0], 1'b0);
    for (int n = 0; n < 12; n++) cyc(1, n < 6, 1'b0);
    for (int n = 0; n < 20; n++) cyc(n % 2 ? 2 : 5, 1'b1, 1'b1);
    for (int n = 0; n < 4000; n++)
      cyc(($urandom % 8 == 0) ? int'($urandom % 256) : int'($urandom % 13),
          bit'($urandom % 2), ($urandom % 4 == 0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule